// File: doc/BRIEF.md
# Sliding-Window Trapezoidal Integrator

This block integrates a stream of signed ADC samples with the trapezoidal rule over a window of fixed length that slides by one sample for every accepted input. A new integral is produced for every sample once the window is full, so downstream logic sees a result at the full sample rate rather than once per window. The window is a run of `N_INT + 1` consecutive samples, which form `N_INT` trapezoid intervals. The deployment setting is 16-bit samples with `N_INT = 8192`. The elaboration default is smaller so that the shift register stays a modest size.

Internally the block keeps a running sum of the window. On each accepted sample it adds the new sample and removes the sample that drops out of the window, which it reads from the last tap of a shift-register delay line. The trapezoidal end corrections give half weight to the oldest and newest samples. To avoid a fractional bit, the result is reported in doubled units: `out_result = 2*sum(window) - oldest - newest`. This is exactly twice the trapezoidal integral. A synchronous clear restarts the fill, and no result is flagged valid until a full window has been collected again.

Top module: `tint_trap_integrator`

## Requirements
- R1: `out_valid` is a one-cycle strobe. It rises in the cycle after the clock edge that accepts a sample (`in_valid` high, `clr` low), and only when that sample completes or extends a full window.
- R2: When `out_valid` is high, `out_result` equals 2·(sum of the last `N_INT+1` accepted samples) minus the oldest of them minus the newest. The values are two's complement, and `out_result` is signed and `OUT_W` bits wide.
- R3: No overflow occurs for any window content. A window made entirely of the most positive sample value, or entirely of the most negative, gives the exact result ±`2·N_INT·|x|`.
- R4: After reset or clear, `out_valid` stays low for the first `N_INT` accepted samples. It first rises for the sample numbered `N_INT+1`.
- R5: In a cycle with `in_valid` low, the window does not advance. `out_valid` is low in the following cycle, and `out_result` keeps its value. Gaps in the stream therefore do not change later results.
- R6: `clr` is synchronous and takes priority over `in_valid`, so a sample presented with `clr` is discarded. After a clear, the window must refill with `N_INT+1` new samples before the next valid result, and no sample from before the clear contributes to it.
- R7: While reset is asserted and after it is released, `out_valid` is 0 and `out_result` is 0 until a valid result is produced.
- R8: Once the window is full, every accepted sample yields a valid result. The window slides by exactly one sample per accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of running sum and fill state |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Signed ADC sample |
| out_valid | output | 1 | Result strobe |
| out_result | output | OUT_W | Signed integral in doubled units |

## Verification
The bench builds the block with `DATA_W = 8` and `N_INT = 4`, which gives a five-sample window and a 13-bit result. This small configuration lets the bench stream every one of the 256 possible sample values through the window. It also lets the bench hold both extreme values long enough to saturate whole windows, and compare every result against a sum computed in the bench. Because the window is short, the bench can also reach fill boundaries, clears during a fill, clears that coincide with a sample, and gaps of varying length many times within a short run.

// File: rtl/tint_pkg.sv
package tint_pkg;
  // Running-sum width: enough for N_INT+1 extreme samples plus one sign margin bit.
  function automatic int sum_width(input int data_w, input int n_int);
    return data_w + $clog2(n_int + 1) + 1;
  endfunction

  // Result is kept in doubled units, so one more bit than the running sum.
  function automatic int out_width(input int data_w, input int n_int);
    return sum_width(data_w, n_int) + 1;
  endfunction
endpackage

// File: rtl/tint_rst_sync.sv
module tint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tint_delay_line.sv
module tint_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 1025
) (
  input  logic                 clk,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] tap_last,
  output logic signed [DW-1:0] tap_prev
);
  logic signed [DW-1:0] stage_q [DEPTH];

  // Plain storage flops: no reset; the fill logic masks stale contents.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (shift_en) stage_q[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (shift_en) stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign tap_last = stage_q[DEPTH-1];
  assign tap_prev = stage_q[DEPTH-2];
endmodule

// File: rtl/tint_fill_ctr.sv
module tint_fill_ctr #(
  parameter int DEPTH = 1025
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic full,
  output logic ready
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                                cnt_n = '0;
    else if (adv && (cnt_q != CW'(DEPTH)))  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign full  = (cnt_q == CW'(DEPTH));
  assign ready = (cnt_q >= CW'(DEPTH - 1));
endmodule

// File: rtl/tint_accum.sv
module tint_accum #(
  parameter int DW    = 16,
  parameter int SUM_W = 28,
  parameter int OUT_W = 29
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    adv,
  input  logic                    full,
  input  logic                    ready,
  input  logic signed [DW-1:0]    din,
  input  logic signed [DW-1:0]    leaving,
  input  logic signed [DW-1:0]    new_oldest,
  output logic                    res_valid,
  output logic signed [OUT_W-1:0] res
);
  logic signed [SUM_W-1:0] sum_q, sum_n, sum_d, leave_eff;
  logic signed [OUT_W-1:0] res_q, res_n, res_d;
  logic                    vld_q, vld_n;

  always_comb begin
    leave_eff = full ? SUM_W'(leaving) : '0;
    sum_d     = sum_q + SUM_W'(din) - leave_eff;
    res_d     = $signed({sum_d, 1'b0}) - OUT_W'(din) - OUT_W'(new_oldest);
    sum_n     = sum_q;
    res_n     = res_q;
    vld_n     = 1'b0;
    if (clr) begin
      sum_n = '0;
    end else if (adv) begin
      sum_n = sum_d;
      if (ready) begin
        res_n = res_d;
        vld_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q <= sum_n;
      res_q <= res_n;
      vld_q <= vld_n;
    end
  end

  assign res_valid = vld_q;
  assign res       = res_q;
endmodule

// File: rtl/tint_trap_integrator.sv
module tint_trap_integrator
  import tint_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int N_INT   = 1024,
  localparam int WIN_LEN = N_INT + 1,
  localparam int SUM_W   = sum_width(DATA_W, N_INT),
  localparam int OUT_W   = out_width(DATA_W, N_INT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_result
);
  logic                     rst_sync_n;
  logic                     adv, full, ready;
  logic signed [DATA_W-1:0] tap_last, tap_prev;

  assign adv = in_valid && !clr;

  tint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tint_delay_line #(.DW(DATA_W), .DEPTH(WIN_LEN)) u_dly (
    .clk      (clk),
    .shift_en (adv),
    .din      (in_sample),
    .tap_last (tap_last),
    .tap_prev (tap_prev)
  );

  tint_fill_ctr #(.DEPTH(WIN_LEN)) u_fill (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .adv   (adv),
    .full  (full),
    .ready (ready)
  );

  tint_accum #(.DW(DATA_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (clr),
    .adv        (adv),
    .full       (full),
    .ready      (ready),
    .din        (in_sample),
    .leaving    (tap_last),
    .new_oldest (tap_prev),
    .res_valid  (out_valid),
    .res        (out_result)
  );
endmodule

// File: rtl/tint_trap_checker.sv
module tint_trap_checker #(
  parameter int DEPTH = 1025,
  parameter int OUT_W = 29
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_result
);
  localparam int CW = $clog2(DEPTH + 1);

  // Independent count of accepted samples since reset or clear, saturating.
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               seen_q <= '0;
    else if (clr)                             seen_q <= '0;
    else if (in_valid && seen_q != CW'(DEPTH)) seen_q <= seen_q + 1'b1;
  end

  a_r1_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !clr));

  a_r4_no_valid_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(seen_q) >= CW'(DEPTH - 1)));

  a_r5_hold_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_result) && !out_valid));

  a_r6_clear_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> !out_valid);

  a_r8_every_sample_once_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && !clr) && ($past(seen_q) == CW'(DEPTH))) |-> out_valid);
endmodule

bind tint_trap_integrator tint_trap_checker #(.DEPTH(WIN_LEN), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .clr        (clr),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/sim_tint_trap_integrator.sv
module sim_tint_trap_integrator;
  localparam int DW  = 8;
  localparam int NI  = 4;
  localparam int WIN = NI + 1;
  localparam int OW  = tint_pkg::out_width(DW, NI);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 clr = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_result;

  int checks = 0;
  int failures = 0;
  int hist[$];
  int last_res = 0;

  always #2 clk = ~clk;

  tint_trap_integrator #(.DATA_W(DW), .N_INT(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample 1 ns after the capturing edge.
  task automatic step(input string tag, input bit v, input int x, input bit c);
    int s;
    int ev;
    @(negedge clk);
    in_valid  = v;
    in_sample = DW'(x);
    clr       = c;
    @(posedge clk);
    #1;
    if (c) begin
      hist.delete();
      check({tag, " R6 clear"}, int'(out_valid), 0);
    end else if (v) begin
      hist.push_front(x);
      if (hist.size() > WIN) void'(hist.pop_back());
      if (hist.size() == WIN) begin
        s = 0;
        foreach (hist[i]) s += hist[i];
        ev = 2 * s - hist[0] - hist[WIN-1];
        check({tag, " R8 valid"}, int'(out_valid), 1);
        check({tag, " R2 value"}, int'(out_result), ev);
        last_res = ev;
      end else begin
        check({tag, " R4 fill"}, int'(out_valid), 0);
      end
    end else begin
      check({tag, " R5 gap valid"}, int'(out_valid), 0);
      check({tag, " R5 gap hold"}, int'(out_result), last_res);
    end
    in_valid = 1'b0;
    clr      = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    #1;
    check("R7 reset valid", int'(out_valid), 0);
    check("R7 reset value", int'(out_result), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 post-reset valid", int'(out_valid), 0);
    check("R7 post-reset value", int'(out_result), 0);

    // R4 / R1: first valid on the fifth sample.
    for (int i = 1; i <= WIN; i++) step("fill", 1'b1, i, 1'b0);

    // R2 / R8: sweep every sample value.
    for (int x = -128; x <= 127; x++) step("sweep", 1'b1, x, 1'b0);

    // R3: saturate the window with both extremes.
    for (int i = 0; i < 2 * WIN; i++) step("R3 max", 1'b1, 127, 1'b0);
    check("R3 max exact", int'(out_result), 2 * NI * 127);
    for (int i = 0; i < 2 * WIN; i++) step("R3 min", 1'b1, -128, 1'b0);
    check("R3 min exact", int'(out_result), -2 * NI * 128);
    for (int i = 0; i < 3 * WIN; i++) step("R3 alt", 1'b1, (i % 2) ? 127 : -128, 1'b0);

    // R5: gaps of varying length inside the stream.
    for (int i = 0; i < 20; i++) begin
      step("gapdata", 1'b1, i * 11 - 90, 1'b0);
      for (int g = 0; g < (i % 3); g++) step("gap", 1'b0, 55, 1'b0);
    end

    // R6: clear in mid-window, clear together with a sample, clear during fill.
    step("R6 a", 1'b0, 0, 1'b1);
    for (int i = 0; i < 3; i++) step("R6 refill", 1'b1, 100 - i, 1'b0);
    step("R6 b", 1'b1, 99, 1'b1);
    for (int i = 0; i < WIN + 3; i++) step("R6 refill2", 1'b1, -7 * i, 1'b0);

    // R2 / R8: pseudo-random stream mixed with gaps.
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step("lfsr", (lfsr[0] | lfsr[1]), $signed(lfsr), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule